// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 32 interrupt sources into one interrupt line for a processor. The source lines arrive asynchronously. Each one passes through a synchronizer, and a rising edge latches a status bit. An enable register masks the status bits. Whenever any status bit is both set and enabled, a registered interrupt output goes high.

Software services an interrupt by reading the index register. That register returns the number of the most urgent pending, enabled source. Software then clears that source by writing a one to its status bit.

Source n occupies bit (31 − n) of every register, so source 0 is the most significant bit. Lower-numbered sources win. The parameter `IMPL_MASK` picks which positions exist. The default provides fourteen positions, sources 0 to 13: six for external pins and eight for on-chip peripherals. Every other position reads as zero and cannot be set.

The register port is a single-cycle port. A write takes effect on the clock edge. A read is combinational from the address. Address 0 is status (write one to clear). Address 1 is enable. Address 2 is the read-only index. Address 3 reads as zero.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, status and enable read 0, `irq_o` is 0, and the index register reads 32'hFFFF_FFFF.
- R2: A rising edge on an implemented source input sets its status bit (bit 31 − n for source n). A source held high does not set the bit again after it has been cleared.
- R3: Positions outside `IMPL_MASK` read 0 in both status and enable, whatever is written and whatever their inputs do.
- R4: A write to address 0 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When a source edge and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to address 1 loads the enable register (masked by `IMPL_MASK`). Clearing an enable bit leaves the matching status bit unchanged.
- R7: `irq_o` equals, one cycle later, the OR of (status AND enable).
- R8: Address 2 reads the lowest source number whose status and enable bits are both 1, zero-extended. It reads 32'hFFFF_FFFF when there is none.
- R9: Writes to address 2 or address 3 change neither status nor enable. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous source lines; bit 31 − n is source n |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 index |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check several properties on every cycle. The interrupt output follows the enabled pending set one cycle late. Unimplemented positions stay at zero. A write-one clear removes the written bits unless an edge arrives in the same cycle. Enable writes load the masked data. The index read returns all ones when nothing is enabled and pending. Writes to the index address disturb nothing.

Only the bench's scenarios can show the rest. These are the priority order between several pending sources and the edge-only setting of a held source. They also include the exact synchronizer latency, and a disabled bit being kept pending until it is enabled again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_IDX  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_impl
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= src_i[b];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign rise_o[b] = sync_q & ~prev_q;
    end else begin : g_void
      assign rise_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned W = 32,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // MSB is source 0; the lowest source number wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (vec_i[int'(W) - 1 - i]) begin
        idx_o = i[IDX_W-1:0];
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'hFFFC_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] status_q, enable_q, pend_vec, clr_vec;
  logic [IDX_W-1:0]  win_idx;
  logic              win_any;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(reg_addr_i);

  irq_edge_sync #(.W(DATA_W), .MASK(IMPL_MASK)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (set_vec)
  );

  assign clr_vec = (reg_we_i && sel == REG_STAT) ? reg_wdata_i : '0;

  // a new edge beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= ((status_q & ~clr_vec) | set_vec) & IMPL_MASK;
      if (reg_we_i && sel == REG_EN) enable_q <= reg_wdata_i & IMPL_MASK;
      irq_o <= |pend_vec;
    end
  end

  assign pend_vec = status_q & enable_q;

  irq_prio_enc #(.W(DATA_W)) u_enc (
    .vec_i (pend_vec),
    .idx_o (win_idx),
    .any_o (win_any)
  );

  always_comb begin
    unique case (sel)
      REG_STAT: reg_rdata_o = status_q;
      REG_EN:   reg_rdata_o = enable_q;
      REG_IDX:  reg_rdata_o = win_any ? {{(DATA_W-IDX_W){1'b0}}, win_idx} : '1;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'hFFFC_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] enable_q,
  input logic [DATA_W-1:0] set_vec
);
  // R7
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(status_q & enable_q)));

  // R3
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q | enable_q) & ~IMPL_MASK) == '0);

  // R4
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_STAT) |=>
      (status_q & $past(reg_wdata_i) & ~$past(set_vec)) == '0);

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> (status_q & $past(set_vec)) == $past(set_vec));

  // R6
  enable_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_EN) |=> enable_q == ($past(reg_wdata_i) & IMPL_MASK));

  // R8
  idx_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & enable_q) == '0 && reg_addr_i == REG_IDX) |-> reg_rdata_o == '1);

  // R9
  idx_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i[1] && set_vec == '0) |=>
      (status_q == $past(status_q) && enable_q == $past(enable_q)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .status_q    (status_q),
  .enable_q    (enable_q),
  .set_vec     (set_vec)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .reg_addr_i(reg_addr_i),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o)
  );

  // op: 0 write, 1 read-compare, 2 drive sources and wait, 3 compare irq_o
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SRC = 2'd2, OP_IRQ = 2'd3;
  localparam logic [1:0] A_ST = 2'd0, A_EN = 2'd1, A_IX = 2'd2, A_NO = 2'd3;
  localparam int NV = 28;
  // {op, req, addr, data, expected}
  localparam logic [71:0] VEC [NV] = '{
    {OP_WR,  4'd6, A_EN, 32'hFFFF_FFFF, 32'h0},
    {OP_RD,  4'd3, A_EN, 32'h0,         32'hFFFC_0000},  // R3 R6
    {OP_SRC, 4'd2, A_ST, 32'h0408_0001, 32'h0},
    {OP_RD,  4'd2, A_ST, 32'h0,         32'h0408_0000},  // R2 R3
    {OP_IRQ, 4'd7, A_ST, 32'h0,         32'h1},          // R7
    {OP_RD,  4'd8, A_IX, 32'h0,         32'h5},          // R8
    {OP_WR,  4'd4, A_ST, 32'h0400_0000, 32'h0},
    {OP_RD,  4'd4, A_ST, 32'h0,         32'h0008_0000},  // R4
    {OP_RD,  4'd8, A_IX, 32'h0,         32'hC},          // R8
    {OP_SRC, 4'd2, A_ST, 32'h0408_0001, 32'h0},
    {OP_RD,  4'd2, A_ST, 32'h0,         32'h0008_0000},  // R2 held level
    {OP_WR,  4'd6, A_EN, 32'h0,         32'h0},
    {OP_RD,  4'd6, A_ST, 32'h0,         32'h0008_0000},  // R6
    {OP_RD,  4'd8, A_IX, 32'h0,         32'hFFFF_FFFF},  // R8
    {OP_IRQ, 4'd7, A_ST, 32'h0,         32'h0},          // R7
    {OP_WR,  4'd9, A_IX, 32'hFFFF_FFFF, 32'h0},
    {OP_WR,  4'd9, A_NO, 32'hFFFF_FFFF, 32'h0},
    {OP_RD,  4'd9, A_EN, 32'h0,         32'h0},          // R9
    {OP_RD,  4'd9, A_ST, 32'h0,         32'h0008_0000},  // R9
    {OP_RD,  4'd9, A_NO, 32'h0,         32'h0},          // R9
    {OP_WR,  4'd6, A_EN, 32'hFFFF_FFFF, 32'h0},
    {OP_SRC, 4'd2, A_ST, 32'h0,         32'h0},
    {OP_SRC, 4'd2, A_ST, 32'h8000_0000, 32'h0},
    {OP_RD,  4'd8, A_IX, 32'h0,         32'h0},          // R8 source 0 wins
    {OP_RD,  4'd2, A_ST, 32'h0,         32'h8008_0000},
    {OP_WR,  4'd4, A_ST, 32'hFFFF_FFFF, 32'h0},
    {OP_RD,  4'd4, A_ST, 32'h0,         32'h0},          // R4
    {OP_IRQ, 4'd7, A_ST, 32'h0,         32'h0}           // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    reg_read(A_ST, rd); check("R1", rd, 32'h0);
    reg_read(A_EN, rd); check("R1", rd, 32'h0);
    reg_read(A_IX, rd); check("R1", rd, 32'hFFFF_FFFF);
    check("R1", {31'h0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [1:0]  ad;
      logic [31:0] dt, ex;
      {op, rq, ad, dt, ex} = VEC[i];
      case (op)
        OP_WR: reg_write(ad, dt);
        OP_RD: begin
          reg_read(ad, rd);
          check($sformatf("R%0d vec%0d", rq, i), rd, ex);
        end
        OP_SRC: begin
          @(negedge clk_i);
          src_i = dt;
          repeat (4) @(negedge clk_i);
        end
        default: begin
          repeat (2) @(negedge clk_i);
          check($sformatf("R%0d vec%0d", rq, i), {31'h0, irq_o}, ex);
        end
      endcase
    end

    // R5: edge lands on the same cycle as a write-one clear of that bit
    @(negedge clk_i);
    src_i = 32'h4000_0000;
    @(negedge clk_i);
    @(negedge clk_i);
    reg_addr_i = A_ST; reg_wdata_i = 32'h4000_0000; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    reg_read(A_ST, rd); check("R5", rd, 32'h4000_0000);
    reg_read(A_IX, rd); check("R5", rd, 32'h1);

    // R1 again: asynchronous reset clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R1", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i);
    src_i = '0;
    rst_ni = 1'b1;
    reg_read(A_ST, rd); check("R1", rd, 32'h0);
    reg_read(A_EN, rd); check("R1", rd, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule